// File: doc/BRIEF.md
# Disk Adapter Control and Status Register Bank

This block is the software-visible register bank of a disk channel adapter. A bus slave selects one of seven 16-bit words through a 3-bit word index, with independent enables for the low and high byte lanes. Inside, it holds the command and status word, the word count, the 16-bit bus address with its 6-bit extension, the unit-select and error word, a data buffer and a secondary status word that carries write-check flags.

Writes have side effects beyond storage. A command write is passed to the drive side as a one-cycle strobe, unless it would start a data transfer while the channel is busy; that case is refused and logged as a program error. A started transfer wipes the old error state. Writing one to the transfer-error bit clears every error flag. Fields that appear in two words (interrupt enable, and the two low address-extension bits) are kept as one stored copy and read identically through both words. A write of the clear bit in the unit-select word resets the whole bank. The DMA engine loads the count and address through a side port, and completion and error events come in as pulses. The interrupt logic observes the enable, done and special-condition outputs.

Top module: `mxa_csr_bank`

## Requirements
- R1: After rst_n low, or after a low-lane write of word 3 with bit 5 set, word 0 reads 0x0080 (DONE, bit 7), word 3 reads 0x00C0, and words 1, 2, 4, 5 and 6 read 0.
- R2: Word index 0 is the command word, 1 the word count, 2 the bus address, 3 the unit/error word, 4 the data buffer, 5 the address extension, 6 the secondary status word. Words 1 and 4 store all 16 bits. Word 2 bit 0 always reads 0. Word 5 stores bits 5:0, and bits 15:6 read 0.
- R3: bus_be_i[0] alone writes only bits 7:0 of words 1, 2 and 4, and bus_be_i[1] alone writes only bits 15:8. The other byte keeps its value.
- R4: A low-lane write of word 0 with bit 0 (start) set, bits 5:1 (function) at octal 24 or more, and DONE clear sets word 3 bit 10 (program error). drv_wr_o stays low.
- R5: Any other low-lane write of word 0 raises drv_wr_o for one cycle, in the cycle after the write, with drv_cmd_o equal to write bits 5:0. If the write starts a transfer, DONE, word 0 bit 14, word 3 bits 15:8 and word 6 bits 15:11 are cleared.
- R6: A high-lane write of word 0 with bit 14 set clears word 0 bit 14, word 3 bits 15:8 and word 6 bits 15:11.
- R7: Word 0 bits 9:8 always equal word 5 bits 1:0. A high-lane write of word 0 changes them only while DONE is set. A write of word 5 updates them.
- R8: Interrupt enable is word 0 bit 6 and word 6 bit 6, and both read the same stored bit. A low-lane write to either word sets it. int_ack_i clears it.
- R9: Word 3 bits 7:6 read 1. Bits 4:0 (unit, inhibit-increment, test) are read/write in the low lane, and bits 9 and 13 are read/write in the high lane. Word 0 bit 14 reads 1 whenever any of word 3 bits 15:8 is set. Word 0 bit 15 reads 1 when bit 14 is set or attn_i is high.
- R10: done_set_i sets DONE. exc_set_i sets DONE and word 0 bit 14. err2_set_i ORs into word 3 bits 15:8, and err3_set_i ORs into word 6 bits 15:11.
- R11: dma_ld_i loads word 1 from dma_wc_i and words 2 and 5 from dma_addr_i (bit 0 forced to 0), taking precedence over a bus write in the same cycle. addr_o equals {word 5 bits 5:0, word 2}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 3 | Word index |
| bus_be_i | input | 2 | Byte-lane enables (bit 0 low byte) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the selected word |
| done_set_i | input | 1 | Transfer completed |
| exc_set_i | input | 1 | Transfer ended with an exception |
| attn_i | input | 1 | Drive attention level |
| err2_set_i | input | 8 | Error flags to OR into word 3 bits 15:8 |
| err3_set_i | input | 5 | Error flags to OR into word 6 bits 15:11 |
| int_ack_i | input | 1 | Interrupt acknowledge, clears enable |
| dma_ld_i | input | 1 | DMA count/address update strobe |
| dma_wc_i | input | 16 | Updated word count |
| dma_addr_i | input | 22 | Updated bus address |
| drv_wr_o | output | 1 | One-cycle command strobe to the drive |
| drv_cmd_o | output | 6 | Function and start bit sent to the drive |
| unit_o | output | 3 | Selected unit |
| inhibit_o | output | 1 | Address increment inhibit |
| wc_o | output | 16 | Current word count |
| addr_o | output | 22 | Current bus address |
| ie_o | output | 1 | Interrupt enable |
| done_o | output | 1 | DONE |
| sc_o | output | 1 | Special condition |

## Verification
A wrong DONE bit shows up at once as a transfer start that is wrongly refused or wrongly accepted. The sign is drv_wr_o missing or present in the cycle after the command write, and word 3 bit 10 changing on the next read. A stuck or lost error flag appears on the next read of word 0 bits 15:14, because those bits summarise word 3. A broken mirror shows up as different values for the same field in its two words. Byte-lane faults corrupt only the untouched byte of the count, address or buffer word, and the randomised lane writes compare every such read against a model.

// File: rtl/mxa_csr_pkg.sv
// Package: word indices and shared constants of the adapter register bank.
// Assumes a 16-bit register word split into two byte lanes.
package mxa_csr_pkg;
    localparam int WORD_W  = 16;
    localparam int HALF_W  = WORD_W / 2;
    localparam int SEL_W   = 3;
    localparam int EXT_W   = 6;
    localparam int ADDR_W  = WORD_W + EXT_W;
    localparam int FUNC_W  = 5;
    localparam int ERR2_W  = 8;
    localparam int ERR3_W  = 5;

    localparam logic [SEL_W-1:0] SEL_CTL1 = 3'd0;
    localparam logic [SEL_W-1:0] SEL_WCNT = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BADR = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTL2 = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DBUF = 3'd4;
    localparam logic [SEL_W-1:0] SEL_AEXT = 3'd5;
    localparam logic [SEL_W-1:0] SEL_CTL3 = 3'd6;

    // lowest function code that moves data
    localparam logic [FUNC_W-1:0] XFER_FUNC_MIN = 5'o24;
endpackage

// File: rtl/mxa_word_reg.sv
// Module: plain data word with byte-lane writes, a side load and a clear.
// Assumes W is even; bits set in ZERO_MASK never store a one.
module mxa_word_reg #(
    parameter int W = 16,
    parameter logic [W-1:0] ZERO_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] q
);
    localparam int H = W / 2;

    // storage: clear, then side load, then per-lane bus write
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_data & ~ZERO_MASK;
        end else begin
            if (wr_lo) q[H-1:0] <= wdata[H-1:0] & ~ZERO_MASK[H-1:0];
            if (wr_hi) q[W-1:H] <= wdata[W-1:H] & ~ZERO_MASK[W-1:H];
        end
    end

    // R2: masked bits never hold a one
    p_mask_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ZERO_MASK) == '0);

    // R3: a high-lane-only write keeps the low byte
    p_lo_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo && !ld && !clr) |=> q[H-1:0] == $past(q[H-1:0]));

    // R3: a low-lane-only write keeps the high byte
    p_hi_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi && !ld && !clr) |=> q[W-1:H] == $past(q[W-1:H]));
endmodule

// File: rtl/mxa_ctl_status.sv
// Module: command, unit/error, extension and secondary status words.
// Holds the state whose writes have side effects: transfer-start checks,
// error clearing, DONE-gated extension writes, shared enable bit and
// the whole-bank clear. Assumes a single word is selected per cycle.
module mxa_ctl_status
    import mxa_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [1:0]        bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              done_set,
    input  logic              exc_set,
    input  logic              attn,
    input  logic [ERR2_W-1:0] err2_set,
    input  logic [ERR3_W-1:0] err3_set,
    input  logic              int_ack,
    input  logic              dma_ld,
    input  logic [EXT_W-1:0]  dma_ext,
    output logic              soft_clr,
    output logic [WORD_W-1:0] ctl1_rd,
    output logic [WORD_W-1:0] ctl2_rd,
    output logic [WORD_W-1:0] ctl3_rd,
    output logic [WORD_W-1:0] aext_rd,
    output logic [EXT_W-1:0]  ext_q,
    output logic              drv_wr,
    output logic [5:0]        drv_cmd,
    output logic [2:0]        unit,
    output logic              inhibit,
    output logic              ie,
    output logic              done,
    output logic              sc
);
    logic              tre_q, pat_q;
    logic [ERR2_W-1:0] err2_q, err2_d;
    logic [ERR3_W-1:0] err3_q, err3_d;
    logic [3:0]        ipck_q;
    logic              w1_lo, w1_hi, w2_lo, w2_hi, wext, w3;
    logic              is_xfer, pge_hit, accept, xfer_ok, err_clr, tre_rd;

    // decode of the selected word and byte lanes
    assign w1_lo = bus_wr && bus_sel == SEL_CTL1 && bus_be[0];
    assign w1_hi = bus_wr && bus_sel == SEL_CTL1 && bus_be[1];
    assign w2_lo = bus_wr && bus_sel == SEL_CTL2 && bus_be[0];
    assign w2_hi = bus_wr && bus_sel == SEL_CTL2 && bus_be[1];
    assign wext  = bus_wr && bus_sel == SEL_AEXT && bus_be[0];
    assign w3    = bus_wr && bus_sel == SEL_CTL3 && bus_be[0];

    // command classification: transfer start, refusal, error clear
    assign is_xfer  = bus_wdata[0] && (bus_wdata[5:1] >= XFER_FUNC_MIN);
    assign pge_hit  = w1_lo && is_xfer && !done;
    assign accept   = w1_lo && !pge_hit;
    assign xfer_ok  = accept && is_xfer;
    assign err_clr  = w1_hi && bus_wdata[14];
    assign soft_clr = w2_lo && bus_wdata[5];

    // next error flags of the unit/error word
    always_comb begin
        err2_d = err2_q;
        if (err_clr || xfer_ok) err2_d = '0;
        if (w2_hi) begin
            err2_d[1] = bus_wdata[9];
            err2_d[5] = bus_wdata[13];
        end
        err2_d = err2_d | err2_set;
        if (pge_hit) err2_d[2] = 1'b1;
    end

    // next write-check flags of the secondary status word
    always_comb begin
        err3_d = err3_q;
        if (err_clr || xfer_ok) err3_d = '0;
        err3_d = err3_d | err3_set;
    end

    // state update: reset/clear first, then events and bus writes
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ie      <= 1'b0;
            done    <= 1'b1;
            tre_q   <= 1'b0;
            ext_q   <= '0;
            unit    <= '0;
            inhibit <= 1'b0;
            pat_q   <= 1'b0;
            err2_q  <= '0;
            err3_q  <= '0;
            ipck_q  <= '0;
            drv_wr  <= 1'b0;
            drv_cmd <= '0;
        end else begin
            if (int_ack)    ie <= 1'b0;
            else if (w1_lo) ie <= bus_wdata[6];
            else if (w3)    ie <= bus_wdata[6];

            if (done_set || exc_set) done <= 1'b1;
            else if (xfer_ok)        done <= 1'b0;

            if (exc_set)                 tre_q <= 1'b1;
            else if (err_clr || xfer_ok) tre_q <= 1'b0;

            if (dma_ld)              ext_q      <= dma_ext;
            else if (wext)           ext_q      <= bus_wdata[EXT_W-1:0];
            else if (w1_hi && done)  ext_q[1:0] <= bus_wdata[9:8];

            if (w2_lo) begin
                unit    <= bus_wdata[2:0];
                inhibit <= bus_wdata[3];
                pat_q   <= bus_wdata[4];
            end
            if (w3) ipck_q <= bus_wdata[3:0];

            err2_q <= err2_d;
            err3_q <= err3_d;
            drv_wr <= accept;
            if (accept) drv_cmd <= bus_wdata[5:0];
        end
    end

    // read images of the four words
    assign tre_rd  = tre_q || (|err2_q);
    assign sc      = tre_rd || attn;
    assign ctl1_rd = {sc, tre_rd, 4'b0000, ext_q[1:0], done, ie, 6'b000000};
    assign ctl2_rd = {err2_q, 2'b11, 1'b0, pat_q, inhibit, unit};
    assign ctl3_rd = {err3_q, 4'b0000, ie, 2'b00, ipck_q};
    assign aext_rd = {{(WORD_W-EXT_W){1'b0}}, ext_q};

    // R4: refused start logs program error and sends nothing
    p_refuse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pge_hit |=> err2_q[2] && !drv_wr);

    // R5: accepted transfer drops DONE unless an event sets it back
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && !done_set && !exc_set) |=> !done && drv_wr);

    // R6: error clear with no new events leaves no error state
    p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && err2_set == '0 && err3_set == '0 && !exc_set)
        |=> err2_q == '0 && err3_q == '0 && !tre_q);

    // R7: extension bits hold while busy
    p_ext_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (w1_hi && !done && !dma_ld) |=> $stable(ext_q[1:0]));

    // R8: acknowledge drops the enable
    p_ack_drops_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !ie);

    // R1: bank clear returns to the idle state
    p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> done && err2_q == '0 && !drv_wr);
endmodule

// File: rtl/mxa_rd_mux.sv
// Module: read multiplexer of the seven register words.
// Assumes an unused index reads zero.
module mxa_rd_mux
    import mxa_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] ctl1,
    input  logic [WORD_W-1:0] wcnt,
    input  logic [WORD_W-1:0] badr,
    input  logic [WORD_W-1:0] ctl2,
    input  logic [WORD_W-1:0] dbuf,
    input  logic [WORD_W-1:0] aext,
    input  logic [WORD_W-1:0] ctl3,
    output logic [WORD_W-1:0] rdata
);
    // word select
    always_comb begin
        unique case (sel)
            SEL_CTL1: rdata = ctl1;
            SEL_WCNT: rdata = wcnt;
            SEL_BADR: rdata = badr;
            SEL_CTL2: rdata = ctl2;
            SEL_DBUF: rdata = dbuf;
            SEL_AEXT: rdata = aext;
            SEL_CTL3: rdata = ctl3;
            default:  rdata = '0;
        endcase
    end

    // R9: ready bits of the unit/error word read as ones
    p_ready_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CTL2) |-> rdata[7:6] == 2'b11);

    // R8: both images of the enable agree
    p_ie_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1[6] == ctl3[6]);
endmodule

// File: rtl/mxa_csr_bank.sv
// Module: top of the adapter register bank. Instantiates the three plain
// data words, the control/status logic and the read multiplexer.
// Assumes synchronous active-low reset and one word access per cycle.
module mxa_csr_bank
    import mxa_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [SEL_W-1:0]  bus_sel_i,
    input  logic [1:0]        bus_be_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    input  logic              done_set_i,
    input  logic              exc_set_i,
    input  logic              attn_i,
    input  logic [ERR2_W-1:0] err2_set_i,
    input  logic [ERR3_W-1:0] err3_set_i,
    input  logic              int_ack_i,
    input  logic              dma_ld_i,
    input  logic [WORD_W-1:0] dma_wc_i,
    input  logic [ADDR_W-1:0] dma_addr_i,
    output logic              drv_wr_o,
    output logic [5:0]        drv_cmd_o,
    output logic [2:0]        unit_o,
    output logic              inhibit_o,
    output logic [WORD_W-1:0] wc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ie_o,
    output logic              done_o,
    output logic              sc_o
);
    localparam int N_WREG = 3;

    logic              soft_clr;
    logic [WORD_W-1:0] wq [N_WREG];
    logic [WORD_W-1:0] ctl1_rd, ctl2_rd, ctl3_rd, aext_rd;
    logic [EXT_W-1:0]  ext_q;

    // plain data words: count, address, buffer
    for (genvar g = 0; g < N_WREG; g++) begin : g_wreg
        localparam logic [SEL_W-1:0]  MY_SEL = (g == 0) ? SEL_WCNT :
                                               (g == 1) ? SEL_BADR : SEL_DBUF;
        localparam logic [WORD_W-1:0] ZMASK  = (g == 1) ? 16'h0001 : 16'h0000;
        logic              hit;
        logic [WORD_W-1:0] ldv;
        assign hit = bus_wr_i && (bus_sel_i == MY_SEL);
        assign ldv = (g == 0) ? dma_wc_i :
                     (g == 1) ? dma_addr_i[WORD_W-1:0] : '0;
        mxa_word_reg #(.W(WORD_W), .ZERO_MASK(ZMASK)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (soft_clr),
            .wr_lo  (hit && bus_be_i[0]),
            .wr_hi  (hit && bus_be_i[1]),
            .wdata  (bus_wdata_i),
            .ld     (dma_ld_i && (g != 2)),
            .ld_data(ldv),
            .q      (wq[g])
        );
    end

    mxa_ctl_status u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr_i),
        .bus_sel  (bus_sel_i),
        .bus_be   (bus_be_i),
        .bus_wdata(bus_wdata_i),
        .done_set (done_set_i),
        .exc_set  (exc_set_i),
        .attn     (attn_i),
        .err2_set (err2_set_i),
        .err3_set (err3_set_i),
        .int_ack  (int_ack_i),
        .dma_ld   (dma_ld_i),
        .dma_ext  (dma_addr_i[ADDR_W-1:WORD_W]),
        .soft_clr (soft_clr),
        .ctl1_rd  (ctl1_rd),
        .ctl2_rd  (ctl2_rd),
        .ctl3_rd  (ctl3_rd),
        .aext_rd  (aext_rd),
        .ext_q    (ext_q),
        .drv_wr   (drv_wr_o),
        .drv_cmd  (drv_cmd_o),
        .unit     (unit_o),
        .inhibit  (inhibit_o),
        .ie       (ie_o),
        .done     (done_o),
        .sc       (sc_o)
    );

    mxa_rd_mux u_mux (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (bus_sel_i),
        .ctl1 (ctl1_rd),
        .wcnt (wq[0]),
        .badr (wq[1]),
        .ctl2 (ctl2_rd),
        .dbuf (wq[2]),
        .aext (aext_rd),
        .ctl3 (ctl3_rd),
        .rdata(bus_rdata_o)
    );

    // DMA-facing copies of count and address
    assign wc_o   = wq[0];
    assign addr_o = {ext_q, wq[1]};

    // R11: address output always carries an even word address
    p_addr_even_r11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[0] == 1'b0);
endmodule

// File: tb/mxa_csr_bank_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus randomised byte-lane writes of the
// plain data words, compared against a bench-side model.
module mxa_csr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [2:0]  bus_sel_i = '0;
    logic [1:0]  bus_be_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic        done_set_i = 1'b0, exc_set_i = 1'b0, attn_i = 1'b0;
    logic [7:0]  err2_set_i = '0;
    logic [4:0]  err3_set_i = '0;
    logic        int_ack_i = 1'b0, dma_ld_i = 1'b0;
    logic [15:0] dma_wc_i = '0;
    logic [21:0] dma_addr_i = '0;
    logic        drv_wr_o;
    logic [5:0]  drv_cmd_o;
    logic [2:0]  unit_o;
    logic        inhibit_o;
    logic [15:0] wc_o;
    logic [21:0] addr_o;
    logic        ie_o, done_o, sc_o;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [15:0] m_word [3];

    mxa_csr_bank dut_i (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_sel_i = sel; bus_be_i = be; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_be_i = '0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] sel, input logic [15:0] exp);
        @(negedge clk);
        bus_sel_i = sel;
        #1;
        chk(req, bus_rdata_o, exp);
    endtask

    // one-cycle pulse of a status input selected by code
    task automatic pulse(input int which, input logic [7:0] v);
        @(negedge clk);
        case (which)
            0: done_set_i = 1'b1;
            1: exc_set_i = 1'b1;
            2: err2_set_i = v;
            3: err3_set_i = v[4:0];
            default: int_ack_i = 1'b1;
        endcase
        @(negedge clk);
        done_set_i = 0; exc_set_i = 0; err2_set_i = '0; err3_set_i = '0; int_ack_i = 0;
    endtask

    // expected value of a byte-lane write of a plain word
    function automatic logic [15:0] merge(input logic [15:0] old, input logic [1:0] be,
                                          input logic [15:0] d, input logic [15:0] zm);
        logic [15:0] r = old;
        if (be[0]) r[7:0] = d[7:0];
        if (be[1]) r[15:8] = d[15:8];
        return r & ~zm;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset image
        rd_chk("R1 w0", 3'd0, 16'h0080);
        rd_chk("R1 w3", 3'd3, 16'h00C0);
        for (int i = 1; i < 7; i++) if (i != 3) rd_chk("R1 zero", i[2:0], 16'h0000);
        for (int i = 0; i < 3; i++) m_word[i] = '0;
        // R2 R3 randomised lane writes of count, address, buffer
        for (int n = 0; n < 300; n++) begin
            int k = int'($urandom_range(0, 2));
            logic [1:0] be = 2'($urandom_range(1, 3));
            logic [15:0] d = 16'($urandom);
            logic [2:0] s = (k == 0) ? 3'd1 : (k == 1) ? 3'd2 : 3'd4;
            m_word[k] = merge(m_word[k], be, d, (k == 1) ? 16'h0001 : 16'h0000);
            wr(s, be, d);
            rd_chk("R3 lane write", s, m_word[k]);
        end
        rd_chk("R2 bit0 of address", 3'd2, m_word[1]);
        // R2 R7 extension word and its mirror
        wr(3'd5, 2'b11, 16'hFFFF);
        rd_chk("R2 ext width", 3'd5, 16'h003F);
        rd_chk("R7 mirror from ext", 3'd0, 16'h0380);
        wr(3'd0, 2'b10, 16'h0100);
        rd_chk("R7 write while done", 3'd5, 16'h003D);
        rd_chk("R7 w0 image", 3'd0, 16'h0180);
        // R8 shared enable, R5 plain command strobe
        wr(3'd0, 2'b01, 16'h0040);
        chk("R5 strobe", drv_wr_o, 1'b1);
        chk("R5 cmd", drv_cmd_o, 6'h00);
        rd_chk("R8 ie in w6", 3'd6, 16'h0040);
        wr(3'd6, 2'b01, 16'h000F);
        rd_chk("R8 ie off via w6", 3'd0, 16'h0180);
        rd_chk("R8 w6", 3'd6, 16'h000F);
        wr(3'd6, 2'b01, 16'h004F);
        rd_chk("R8 ie on via w6", 3'd0, 16'h01C0);
        pulse(4, 8'h00);
        rd_chk("R8 ack", 3'd6, 16'h000F);
        // R10 R9 error inputs and summary bits
        pulse(2, 8'h08);
        pulse(3, 8'h01);
        rd_chk("R9 tre sc from w3", 3'd0, 16'hC180);
        rd_chk("R10 w3 err", 3'd3, 16'h08C0);
        rd_chk("R10 w6 err", 3'd6, 16'h080F);
        // R5 transfer start clears errors and DONE
        wr(3'd0, 2'b01, 16'h0029);
        chk("R5 strobe xfer", drv_wr_o, 1'b1);
        chk("R5 cmd xfer", drv_cmd_o, 6'h29);
        rd_chk("R5 w0 busy", 3'd0, 16'h0100);
        rd_chk("R5 w3 cleared", 3'd3, 16'h00C0);
        rd_chk("R5 w6 cleared", 3'd6, 16'h000F);
        // R7 extension write refused while busy
        wr(3'd0, 2'b10, 16'h0200);
        rd_chk("R7 busy gate", 3'd0, 16'h0100);
        // R5 non-transfer command accepted while busy
        wr(3'd0, 2'b01, 16'h0003);
        chk("R5 busy non-xfer", drv_wr_o, 1'b1);
        // R4 transfer start while busy
        wr(3'd0, 2'b01, 16'h0029);
        chk("R4 no strobe", drv_wr_o, 1'b0);
        rd_chk("R4 prog err", 3'd3, 16'h04C0);
        rd_chk("R4 w0", 3'd0, 16'hC100);
        // R6 error clear
        wr(3'd0, 2'b10, 16'h4000);
        rd_chk("R6 w3", 3'd3, 16'h00C0);
        rd_chk("R6 w0", 3'd0, 16'h0100);
        // R10 done and exception events
        pulse(0, 8'h00);
        rd_chk("R10 done", 3'd0, 16'h0180);
        pulse(1, 8'h00);
        rd_chk("R10 exc", 3'd0, 16'hC180);
        wr(3'd0, 2'b10, 16'h4100);
        rd_chk("R6 tre clear", 3'd0, 16'h0180);
        pulse(3, 8'h10);
        rd_chk("R10 w6 bit15", 3'd6, 16'h800F);
        wr(3'd0, 2'b10, 16'h4100);
        rd_chk("R6 w6 clear", 3'd6, 16'h000F);
        @(negedge clk); attn_i = 1'b1;
        rd_chk("R9 attn", 3'd0, 16'h8180);
        @(negedge clk); attn_i = 1'b0;
        // R9 unit/error word fields
        wr(3'd3, 2'b01, 16'h001F);
        rd_chk("R9 low fields", 3'd3, 16'h00DF);
        chk("R9 unit", unit_o, 3'd7);
        chk("R9 inhibit", inhibit_o, 1'b1);
        wr(3'd3, 2'b10, 16'h2200);
        rd_chk("R9 high fields", 3'd3, 16'h22DF);
        rd_chk("R9 summary", 3'd0, 16'hC180);
        wr(3'd0, 2'b10, 16'h4100);
        // R11 DMA load beats a same-cycle bus write
        @(negedge clk);
        dma_ld_i = 1'b1; dma_wc_i = 16'h1234; dma_addr_i = 22'h2A5679;
        bus_wr_i = 1'b1; bus_sel_i = 3'd1; bus_be_i = 2'b11; bus_wdata_i = 16'hFFFF;
        @(negedge clk);
        dma_ld_i = 1'b0; bus_wr_i = 1'b0; bus_be_i = '0;
        rd_chk("R11 wc", 3'd1, 16'h1234);
        rd_chk("R11 ba", 3'd2, 16'h5678);
        rd_chk("R11 ext", 3'd5, 16'h002A);
        rd_chk("R7 mirror from dma", 3'd0, 16'h0280);
        chk("R11 addr_o", addr_o, 22'h2A5678);
        // R1 whole-bank clear
        wr(3'd3, 2'b01, 16'h0020);
        rd_chk("R1 clr w0", 3'd0, 16'h0080);
        rd_chk("R1 clr w3", 3'd3, 16'h00C0);
        rd_chk("R1 clr w1", 3'd1, 16'h0000);
        rd_chk("R1 clr w6", 3'd6, 16'h0000);
        rd_chk("R1 clr w5", 3'd5, 16'h0000);
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule